// File: doc/BRIEF.md
# Transmit De-emphasis FIR Level Encoder

This block turns a serial bit stream into a signed drive level for each unit interval (UI). Every accepted input bit is one UI. The level is a weighted sum of the current bit and the bits of the previous UIs. The weights are a cursor coefficient and a set of post-cursor coefficients, and they can be programmed. The result drives a segmented current-mode output stage or a DAC. The weights are applied so that the first bit after a change of value gets the full amplitude. Repeated bits settle to a lower shelf. A return to zero after a run of ones dips below the base level by the post-cursor weight. A long run of zeros always sits at level 0.

Coefficients are unsigned fractions in which the value 1.0 is 128. A centring mode can be selected. It shifts every level down by half of the distance between the largest and smallest steady levels, so that the output swings evenly around zero. A new coefficient set, together with its centring choice, is written with a single load strobe. Each output level is therefore computed from exactly one coefficient set.

Bits enter on a valid/ready input and levels leave on a valid/ready output. A single output register sits between them. The input is ready whenever that register is empty or the consumer is taking its contents in the same cycle. A level that has been offered and not yet taken stays unchanged. The delay line moves forward only when a bit is accepted, so gaps and stalls never insert extra UIs.

Top module: `txfir_deemph_enc`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1, the active coefficients are cursor 128, all post-cursor taps 0 and centring off, and the bit history is all zeros, so the first accepted bit is computed as if it followed zeros.
- R2: For an accepted bit b0 with history b1 (one UI earlier) and b2 (two UIs earlier), the raw level is C0·b0 − C1·b1 − C2·b2. This equals the cursor term plus each post-cursor coefficient weighted by the complement of its delayed bit, minus the constant that makes the all-zero level 0. It is output as 12-bit two's complement, with 128 meaning 1.0.
- R3: With C0=96, C1=32, C2=0 (6 dB de-emphasis), the bits 0,1,1,1,0,0,0 straight after reset give the levels 0, 96, 64, 64, −32, 0, 0.
- R4: With centring on, every level is reduced by floor((C0 − C1 − C2)/2). For the R3 setting, the same bits give −32, 64, 32, 32, −64, −32, −32.
- R5: cfg_c0, cfg_post and cfg_center are captured only in a cycle with cfg_load high, and they are ignored at all other times. A bit accepted in the same cycle as a load still uses the previous set. cfg_post holds tap n (delay n UI) in bits [8n-1 : 8n-8], so C1 is in bits 7:0.
- R6: A bit accepted at a clock edge produces its level with out_valid high directly after that edge, which is one UI of latency.
- R7: in_ready equals (not out_valid) or out_ready. While out_valid is high and out_ready is low, out_valid stays high and out_level does not change.
- R8: With C2 = 0, the level depends only on the current bit and the previous bit. This is plain two-tap de-emphasis.
- R9: The history moves forward only on accepted bits. Cycles without in_valid, and cycles stalled by the output, do not change the history seen by later bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input bit present |
| in_ready | output | 1 | Block can accept a bit |
| in_bit | input | 1 | Data bit for this UI |
| out_valid | output | 1 | out_level holds a level |
| out_ready | input | 1 | Consumer takes the level |
| out_level | output | 12 | Signed drive level, 128 = 1.0 |
| cfg_load | input | 1 | Capture the coefficient set and the centring choice |
| cfg_c0 | input | 8 | Cursor coefficient |
| cfg_post | input | 16 | Post-cursor coefficients, tap 1 in the low byte |
| cfg_center | input | 1 | 1 selects centred levels |

## Verification
The hardest case to reach is a coefficient load that lands on a cycle where a bit is accepted while the output is stalled, or while input gaps are holding the history still. In that case the old set and the new set are easy to tell apart only through later levels. The stimulus runs long streams in which valid, ready and the bit values are all random. The coefficient inputs change every cycle. Loads are asserted occasionally on arbitrary cycles. A bench model that applies each load after computing the level of the same cycle predicts every level. The coefficient sets include odd and negative centring bases, so the rounding of the offset is also exercised.

// File: rtl/txfir_pkg.sv
`timescale 1ns/1ps
package txfir_pkg;
  typedef enum logic {
    LVL_RAW      = 1'b0,
    LVL_CENTRED  = 1'b1
  } level_mode_e;

  // Output width: coefficient bits, growth from summing taps, sign, headroom for the offset.
  function automatic int level_width(input int coef_w, input int post_taps);
    return coef_w + $clog2(post_taps + 1) + 2;
  endfunction
endpackage

// File: rtl/txfir_hist.sv
`timescale 1ns/1ps
module txfir_hist #(
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift,
  input  logic             bit_in,
  output logic [DEPTH-1:0] hist
);
  generate
    if (DEPTH == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n)     hist <= '0;
        else if (shift) hist <= bit_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (!rst_n)     hist <= '0;
        else if (shift) hist <= {hist[DEPTH-2:0], bit_in};
      end

      AST_HIST_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        shift |=> hist[DEPTH-1:1] == $past(hist[DEPTH-2:0])); // R9
    end
  endgenerate

  AST_HIST_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    shift |=> hist[0] == $past(bit_in)); // R9
  AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !shift |=> $stable(hist)); // R9
endmodule

// File: rtl/txfir_coef.sv
`timescale 1ns/1ps
module txfir_coef #(
  parameter int COEF_W    = 8,
  parameter int POST_TAPS = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load,
  input  logic [COEF_W-1:0]             c0_in,
  input  logic [POST_TAPS*COEF_W-1:0]   post_in,
  input  txfir_pkg::level_mode_e        mode_in,
  output logic [COEF_W-1:0]             c0,
  output logic [POST_TAPS*COEF_W-1:0]   post,
  output txfir_pkg::level_mode_e        mode
);
  localparam logic [COEF_W-1:0] UNITY = COEF_W'(1) << (COEF_W - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c0   <= UNITY;
      post <= '0;
      mode <= txfir_pkg::LVL_RAW;
    end else if (load) begin
      c0   <= c0_in;
      post <= post_in;
      mode <= mode_in;
    end
  end

  AST_COEF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable({c0, post, mode})); // R5
  AST_COEF_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> c0 == $past(c0_in) && post == $past(post_in)); // R5
endmodule

// File: rtl/txfir_sum.sv
`timescale 1ns/1ps
module txfir_sum #(
  parameter int COEF_W    = 8,
  parameter int POST_TAPS = 2,
  parameter int LEVEL_W   = 12
) (
  input  logic                              bit_now,
  input  logic [POST_TAPS-1:0]              hist,
  input  logic [COEF_W-1:0]                 c0,
  input  logic [POST_TAPS*COEF_W-1:0]       post,
  input  txfir_pkg::level_mode_e            mode,
  output logic signed [LEVEL_W-1:0]         level
);
  localparam int PAD = LEVEL_W - COEF_W;

  function automatic logic signed [LEVEL_W-1:0] widen(input logic [COEF_W-1:0] c);
    return $signed({{PAD{1'b0}}, c});
  endfunction

  // run: accumulated level over taps; base: cursor minus every post tap (swing midpoint x2)
  logic signed [LEVEL_W-1:0] run  [POST_TAPS+1];
  logic signed [LEVEL_W-1:0] base [POST_TAPS+1];
  logic signed [LEVEL_W-1:0] offset;

  assign run[0]  = bit_now ? widen(c0) : '0;
  assign base[0] = widen(c0);

  generate
    for (genvar g = 0; g < POST_TAPS; g++) begin : g_tap
      logic [COEF_W-1:0] coef;
      assign coef      = post[g*COEF_W +: COEF_W];
      assign run[g+1]  = run[g] - (hist[g] ? widen(coef) : '0);
      assign base[g+1] = base[g] - widen(coef);
    end
  endgenerate

  assign offset = base[POST_TAPS] >>> 1;
  assign level  = (mode == txfir_pkg::LVL_CENTRED) ? run[POST_TAPS] - offset
                                                   : run[POST_TAPS];
endmodule

// File: rtl/txfir_deemph_enc.sv
`timescale 1ns/1ps
module txfir_deemph_enc #(
  parameter  int COEF_W    = 8,
  parameter  int POST_TAPS = 2,
  localparam int LEVEL_W   = txfir_pkg::level_width(COEF_W, POST_TAPS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic                        in_bit,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [LEVEL_W-1:0]          out_level,
  input  logic                        cfg_load,
  input  logic [COEF_W-1:0]           cfg_c0,
  input  logic [POST_TAPS*COEF_W-1:0] cfg_post,
  input  logic                        cfg_center
);
  logic                        accept;
  logic [POST_TAPS-1:0]        hist;
  logic [COEF_W-1:0]           act_c0;
  logic [POST_TAPS*COEF_W-1:0] act_post;
  txfir_pkg::level_mode_e      act_mode;
  txfir_pkg::level_mode_e      mode_in;
  logic signed [LEVEL_W-1:0]   next_level;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign mode_in  = cfg_center ? txfir_pkg::LVL_CENTRED : txfir_pkg::LVL_RAW;

  txfir_hist #(.DEPTH(POST_TAPS)) u_hist (
    .clk    (clk),
    .rst_n  (rst_n),
    .shift  (accept),
    .bit_in (in_bit),
    .hist   (hist)
  );

  txfir_coef #(.COEF_W(COEF_W), .POST_TAPS(POST_TAPS)) u_coef (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (cfg_load),
    .c0_in   (cfg_c0),
    .post_in (cfg_post),
    .mode_in (mode_in),
    .c0      (act_c0),
    .post    (act_post),
    .mode    (act_mode)
  );

  txfir_sum #(.COEF_W(COEF_W), .POST_TAPS(POST_TAPS), .LEVEL_W(LEVEL_W)) u_sum (
    .bit_now (in_bit),
    .hist    (hist),
    .c0      (act_c0),
    .post    (act_post),
    .mode    (act_mode),
    .level   (next_level)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_level <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_level <= next_level;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_level)); // R7
  AST_ACCEPT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid); // R6
  AST_EMPTY_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready); // R7
  AST_IDLE_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid && out_ready |=> !out_valid); // R6
endmodule

// File: tb/tb_txfir_deemph_enc.sv
`timescale 1ns/1ps
module tb_txfir_deemph_enc;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, in_valid, in_bit, out_ready, cfg_load, cfg_center;
  logic [7:0]  cfg_c0;
  logic [15:0] cfg_post;
  wire         in_ready, out_valid;
  wire  [11:0] out_level;

  txfir_deemph_enc dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_bit(in_bit), .out_valid(out_valid), .out_ready(out_ready),
    .out_level(out_level), .cfg_load(cfg_load), .cfg_c0(cfg_c0),
    .cfg_post(cfg_post), .cfg_center(cfg_center)
  );

  int    checks = 0;
  int    errors = 0;
  string ph = "R1";
  // bench model state
  int mc0, mc1, mc2, mlvl;
  bit mcen, mv, mh1, mh2;

  task automatic check_eq(input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", ph, what, got, exp);
    end
  endtask

  function automatic int model_level(input bit b);
    int r;
    r = mc0 * b - mc1 * mh1 - mc2 * mh2;
    if (mcen) r = r - ((mc0 - mc1 - mc2) >>> 1);
    return r;
  endfunction

  task automatic model_reset();
    mc0 = 128; mc1 = 0; mc2 = 0; mcen = 0; mv = 0; mh1 = 0; mh2 = 0; mlvl = 0;
  endtask

  // called at a negedge; returns at the following negedge
  task automatic step(input bit v, input bit b, input bit r, input bit ld,
                      input logic [7:0] c0, input logic [15:0] cp, input bit cen);
    bit acc;
    in_valid = v; in_bit = b; out_ready = r;
    cfg_load = ld; cfg_c0 = c0; cfg_post = cp; cfg_center = cen;
    #1;
    check_eq("in_ready", int'(in_ready), int'(!mv || r)); // R7
    @(posedge clk);
    acc = v && (!mv || r);
    if (acc) begin mlvl = model_level(b); mv = 1; end
    else if (r) mv = 0;
    if (acc) begin mh2 = mh1; mh1 = b; end
    if (ld) begin mc0 = c0; mc1 = int'(cp[7:0]); mc2 = int'(cp[15:8]); mcen = cen; end
    @(negedge clk);
    check_eq("out_valid", int'(out_valid), int'(mv)); // R6
    if (mv) check_eq("out_level", int'($signed(out_level)), mlvl); // R2
  endtask

  task automatic do_reset();
    rst_n = 0; in_valid = 0; in_bit = 0; out_ready = 0;
    cfg_load = 0; cfg_c0 = 0; cfg_post = 0; cfg_center = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    model_reset();
    #1;
  endtask

  task automatic run_seq(input string tag, input bit cen, input int exp_lv[7]);
    bit bits[7] = '{0, 1, 1, 1, 0, 0, 0};
    do_reset();
    ph = tag;
    step(0, 0, 1, 1, 8'd96, {8'd0, 8'd32}, cen);
    for (int i = 0; i < 7; i++) begin
      step(1, bits[i], 1, 0, 8'd0, 16'd0, 0);
      check_eq("sequence level", int'($signed(out_level)), exp_lv[i]);
    end
  endtask

  initial begin
    int set_c0[8]  = '{96, 96, 80, 255, 91, 10, 255, 120};
    int set_c1[8]  = '{32, 32, 32, 127, 40, 40, 255, 60};
    int set_c2[8]  = '{0,  0,  16, 128, 20, 21, 255, 0};
    bit set_cn[8]  = '{0,  1,  0,  1,   1,  1,  1,   0};

    // R1: reset state and first bit after reset
    do_reset();
    ph = "R1";
    check_eq("out_valid after reset", int'(out_valid), 0);
    check_eq("in_ready after reset", int'(in_ready), 1);
    step(1, 1, 1, 0, 8'hAA, 16'h5555, 1);
    check_eq("first level after reset", int'($signed(out_level)), 128);

    // R3 and R4: 6 dB sequence, raw and centred
    run_seq("R3", 0, '{0, 96, 64, 64, -32, 0, 0});
    run_seq("R4", 1, '{-32, 64, 32, 32, -64, -32, -32});

    // R7: hold under back-pressure, then drain
    ph = "R7";
    step(1, 1, 0, 0, 8'd0, 16'd0, 0);
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 8'd0, 16'd0, 0);
    step(0, 0, 1, 0, 8'd0, 16'd0, 0);
    step(0, 0, 1, 0, 8'd0, 16'd0, 0);

    // R2/R5/R8/R9 sweep: random flow control, random cfg noise, occasional loads
    for (int s = 0; s < 8; s++) begin
      do_reset();
      ph = (set_c2[s] == 0) ? "R8" : "R2/R5/R9";
      step(($urandom % 2) == 1, ($urandom % 2) == 1, 1, 1, 8'(set_c0[s]),
           {8'(set_c2[s]), 8'(set_c1[s])}, set_cn[s]);
      for (int i = 0; i < 400; i++) begin
        bit ld;
        ld = (set_c2[s] != 0) && (($urandom % 32) == 0);
        step(($urandom % 4) != 0, ($urandom % 2) == 1, ($urandom % 3) != 0, ld,
             8'($urandom), 16'($urandom), ($urandom % 2) == 1);
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(64'd200000 * 20);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule